// File: doc/BRIEF.md
# Stream-to-Memory Ingress Rule Monitor

This block sits beside a stream link that feeds the write channel of a stream-to-memory DMA engine. It observes the handshake without driving it. It checks the packet discipline that such a channel depends on. Data may flow only after the channel has been armed with a byte length. The last beat must land exactly on that length. The valid signal must drop in the cycle that follows the last beat. Any breach latches a sticky error bit, so a debug probe or a status collector can see it long after the event.

A controller pulses `arm` with the programmed buffer length once the channel is ready. The monitor then counts accepted beats in bytes, at DATA_W/8 bytes per beat. When the packet ends it issues a one-cycle completion pulse carrying the total, and it goes back to waiting for the next arm strobe. The monitor ignores `tready` while it is not armed, because the DMA engine may toggle it at random while it resets itself.

Top module: `s2m_ingress_monitor`

## Requirements
- R1: While armed, every rising clock edge with `tvalid` and `tready` both high adds DATA_W/8 bytes to `rx_bytes`. An edge with either signal low leaves `rx_bytes` unchanged.
- R2: An armed beat with `tlast` high completes the packet. In the next cycle `pkt_done` is high for exactly one cycle, `done_bytes` shows the packet's byte total including that beat, and `rx_bytes` is back to 0. `done_bytes` holds that value until the next completion.
- R3: `tvalid` high at an edge while unarmed sets `mon_err[0]` (early valid). This includes the edge at which `arm` is sampled, because arming takes effect one cycle later.
- R4: `tvalid` high at the edge right after a completing beat sets `mon_err[3]` (trailing valid), and it does not set `mon_err[0]`.
- R5: A completing beat whose byte total is below the armed length sets `mon_err[1]` (short packet). The packet still completes as in R2.
- R6: A beat without `tlast` that brings the byte total to the armed length or beyond sets `mon_err[2]` (missing last).
- R7: A packet whose `tlast` beat brings the total exactly to the armed length completes with no error bit set.
- R8: After completion the monitor is unarmed, and a new `arm` strobe is needed before further beats. An `arm` sampled at the edge right after the completing beat is accepted. An `arm` while already armed is ignored, and the length latched first stays in force.
- R9: While unarmed, toggling `tready` with `tvalid` low sets no error bit and leaves `rx_bytes` at 0.
- R10: Error bits stay set until `rst_n` is sampled low at a clock edge. Reset clears `mon_err`, `pkt_done`, `done_bytes` and `rx_bytes` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the monitored link |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle strobe: the channel is ready for one packet |
| arm_len | input | LEN_W | Programmed packet length in bytes, sampled with `arm` |
| tvalid | input | 1 | Stream valid from the upstream source |
| tready | input | 1 | Stream ready from the DMA channel |
| tlast | input | 1 | End-of-packet marker from the upstream source |
| mon_err | output | 4 | Sticky flags: [0] early valid, [1] short, [2] missing last, [3] trailing valid |
| pkt_done | output | 1 | One-cycle pulse after a completing beat |
| done_bytes | output | LEN_W+1 | Byte total of the most recently completed packet |
| rx_bytes | output | LEN_W+1 | Bytes accepted so far in the current packet |

## Verification
The in-line properties assume that `rst_n` is held low for at least one edge before traffic, and that `arm_len` is a non-zero multiple of DATA_W/8 whenever a packet is meant to be legal. The directed stimulus changes inputs only on falling edges. It raises `arm` in a cycle with `tvalid` low unless an early-valid breach is the point of the test. It resets the block between scenarios, so each error bit is seen alone. Arming lengths stay far below the counter range, so saturation never masks a count.

// File: rtl/s2m_mon_pkg.sv
package s2m_mon_pkg;

   typedef enum logic [1:0] {
      PH_UNARMED = 2'd0,
      PH_ARMED   = 2'd1,
      PH_TAIL    = 2'd2
   } phase_e;

   localparam int unsigned NUM_ERR  = 4;
   localparam int unsigned E_EARLY  = 0;
   localparam int unsigned E_SHORT  = 1;
   localparam int unsigned E_NOLAST = 2;
   localparam int unsigned E_TRAIL  = 3;

endpackage

// File: rtl/s2m_mon_phase.sv
module s2m_mon_phase
   import s2m_mon_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   arm_i,
   input  logic   end_beat_i,
   output phase_e phase_o,
   output logic   arm_take_o
);

   phase_e phase_q;

   // an arm strobe is honoured only when no packet is in flight
   assign arm_take_o = arm_i && (phase_q != PH_ARMED);
   assign phase_o    = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_UNARMED;
      end else begin
         case (phase_q)
            PH_UNARMED: if (arm_i) phase_q <= PH_ARMED;
            PH_ARMED:   if (end_beat_i) phase_q <= PH_TAIL;
            PH_TAIL:    phase_q <= arm_i ? PH_ARMED : PH_UNARMED;
            default:    phase_q <= PH_UNARMED;
         endcase
      end
   end

   // R8: the tail window lasts one cycle and falls back to unarmed without a strobe
   a_r8_tail_release : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_TAIL && !arm_i) |=> (phase_q == PH_UNARMED));

   // R8: an armed channel stays armed until a completing beat
   a_r8_hold_armed : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ARMED && !end_beat_i) |=> (phase_q == PH_ARMED));

endmodule

// File: rtl/s2m_mon_bytecount.sv
module s2m_mon_bytecount #(
   parameter int unsigned LEN_W    = 16,
   parameter int unsigned STEP     = 4,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned CNT_W   = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             beat_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_next_o,
   output logic             under_o,
   output logic             reached_o
);

   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   sum_w;
   logic [CNT_W-1:0] len_x;

   assign sum_w = {1'b0, cnt_q} + (CNT_W+1)'(STEP);
   assign len_x = {1'b0, len_q};

   generate
      if (SATURATE) begin : g_sat
         assign cnt_next_o = sum_w[CNT_W] ? {CNT_W{1'b1}} : sum_w[CNT_W-1:0];
      end else begin : g_wrap
         assign cnt_next_o = sum_w[CNT_W-1:0];
      end
   endgenerate

   assign under_o   = (cnt_next_o < len_x);
   assign reached_o = (cnt_next_o >= len_x);
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (load_i) begin
         len_q <= len_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i || load_i) begin
         cnt_q <= '0;
      end else if (beat_i) begin
         cnt_q <= cnt_next_o;
      end
   end

   // R1: with no beat, no load and no clear, the byte total does not move
   a_r1_idle_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_i && !clear_i && !load_i) |=> $stable(cnt_o));

   // R8: the latched length changes only through a load
   a_r8_len_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(len_q));

endmodule

// File: rtl/s2m_mon_flags.sv
module s2m_mon_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] flags_o
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_o[i] <= 1'b0;
            end else if (set_i[i]) begin
               flags_o[i] <= 1'b1;
            end
         end

         // R10: once raised, a flag survives every cycle until reset
         a_r10_sticky : assert property (@(posedge clk) disable iff (!rst_n)
            flags_o[i] |=> flags_o[i]);
      end
   endgenerate

endmodule

// File: rtl/s2m_ingress_monitor.sv
module s2m_ingress_monitor
   import s2m_mon_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LEN_W    = 16,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned STEP    = DATA_W / 8,
   localparam int unsigned CNT_W   = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [LEN_W-1:0] arm_len,
   input  logic             tvalid,
   input  logic             tready,
   input  logic             tlast,
   output logic [3:0]       mon_err,
   output logic             pkt_done,
   output logic [CNT_W-1:0] done_bytes,
   output logic [CNT_W-1:0] rx_bytes
);

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be a whole number of bytes");
      end
      if (LEN_W < 2 || LEN_W > 31) begin : g_bad_len_w
         $error("LEN_W must lie between 2 and 31");
      end
      if (NUM_ERR != 4) begin : g_bad_err_n
         $error("error vector width does not match the port");
      end
   endgenerate

   phase_e           phase;
   logic             arm_take;
   logic             beat;
   logic             end_beat;
   logic [CNT_W-1:0] cnt_next;
   logic             under;
   logic             reached;
   logic [NUM_ERR-1:0] err_set;
   logic             done_q;
   logic [CNT_W-1:0] done_bytes_q;

   assign beat     = (phase == PH_ARMED) && tvalid && tready;
   assign end_beat = beat && tlast;

   s2m_mon_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm),
      .end_beat_i (end_beat),
      .phase_o    (phase),
      .arm_take_o (arm_take)
   );

   s2m_mon_bytecount #(
      .LEN_W    (LEN_W),
      .STEP     (STEP),
      .SATURATE (SATURATE)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (arm_take),
      .len_i      (arm_len),
      .beat_i     (beat),
      .clear_i    (end_beat),
      .cnt_o      (rx_bytes),
      .cnt_next_o (cnt_next),
      .under_o    (under),
      .reached_o  (reached)
   );

   always_comb begin
      err_set           = '0;
      err_set[E_EARLY]  = (phase == PH_UNARMED) && tvalid;
      err_set[E_SHORT]  = end_beat && under;
      err_set[E_NOLAST] = beat && !tlast && reached;
      err_set[E_TRAIL]  = (phase == PH_TAIL) && tvalid;
   end

   s2m_mon_flags #(
      .N (NUM_ERR)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (err_set),
      .flags_o (mon_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q       <= 1'b0;
         done_bytes_q <= '0;
      end else begin
         done_q <= end_beat;
         if (end_beat) done_bytes_q <= cnt_next;
      end
   end

   assign pkt_done   = done_q;
   assign done_bytes = done_bytes_q;

   // R3: valid while unarmed is always caught one cycle later
   a_r3_early_caught : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UNARMED && tvalid) |=> mon_err[E_EARLY]);

   // R2: completion is a single-cycle pulse
   a_r2_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> !pkt_done);

   // R2: the running total is cleared when completion is reported
   a_r2_done_clears : assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> (rx_bytes == '0));

   // R9: no bytes accumulate while unarmed, whatever tready does
   a_r9_unarmed_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UNARMED) |-> (rx_bytes == '0));

   // R4: valid in the tail window is reported as trailing, not early
   a_r4_trail_class : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TAIL && tvalid && !mon_err[E_EARLY]) |=> (mon_err[E_TRAIL] && !mon_err[E_EARLY]));

endmodule

// File: tb/s2m_ingress_monitor_bench.sv
module s2m_ingress_monitor_bench;

   localparam int LEN_W = 16;
   localparam int CNT_W = LEN_W + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             arm = 1'b0;
   logic [LEN_W-1:0] arm_len = '0;
   logic             tvalid = 1'b0;
   logic             tready = 1'b0;
   logic             tlast = 1'b0;
   logic [3:0]       mon_err;
   logic             pkt_done;
   logic [CNT_W-1:0] done_bytes;
   logic [CNT_W-1:0] rx_bytes;

   int n_chk = 0;
   int n_bad = 0;
   bit summary_done = 1'b0;

   always #5 clk = ~clk;

   s2m_ingress_monitor #(.DATA_W(32), .LEN_W(LEN_W)) u_s2m_ingress_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .arm_len    (arm_len),
      .tvalid     (tvalid),
      .tready     (tready),
      .tlast      (tlast),
      .mon_err    (mon_err),
      .pkt_done   (pkt_done),
      .done_bytes (done_bytes),
      .rx_bytes   (rx_bytes)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive one cycle from a falling edge; return at the next falling edge
   task automatic cyc(input bit v, input bit r, input bit l, input bit a, input int alen);
      tvalid  = v;
      tready  = r;
      tlast   = l;
      arm     = a;
      arm_len = LEN_W'(alen);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R10", "err after reset", int'(mon_err), 0);
      chk("R10", "done after reset", int'(pkt_done), 0);
      chk("R10", "done_bytes after reset", int'(done_bytes), 0);
      chk("R10", "rx_bytes after reset", int'(rx_bytes), 0);
   endtask

   task automatic t_exact();
      do_reset();
      cyc(0, 0, 0, 1, 16);
      cyc(1, 1, 0, 0, 0);
      chk("R1", "rx after beat 1", int'(rx_bytes), 4);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      chk("R1", "rx after beat 3", int'(rx_bytes), 12);
      cyc(1, 1, 1, 0, 0);
      chk("R2", "done pulse", int'(pkt_done), 1);
      chk("R2", "done_bytes", int'(done_bytes), 16);
      chk("R2", "rx cleared", int'(rx_bytes), 0);
      chk("R7", "no errors on exact packet", int'(mon_err), 0);
      cyc(0, 0, 0, 0, 0);
      chk("R2", "pulse one cycle", int'(pkt_done), 0);
      chk("R2", "done_bytes held", int'(done_bytes), 16);
      chk("R7", "still clean", int'(mon_err), 0);
   endtask

   task automatic t_backpressure();
      do_reset();
      for (int i = 0; i < 6; i++) cyc(0, i[0], 0, 0, 0);
      chk("R9", "rx while unarmed", int'(rx_bytes), 0);
      chk("R9", "no error from tready", int'(mon_err), 0);
      cyc(0, 0, 0, 1, 12);
      cyc(1, 0, 0, 0, 0);
      chk("R1", "valid without ready", int'(rx_bytes), 0);
      cyc(0, 1, 0, 0, 0);
      chk("R1", "ready without valid", int'(rx_bytes), 0);
      cyc(1, 1, 0, 0, 0);
      chk("R1", "first beat", int'(rx_bytes), 4);
      cyc(1, 0, 0, 0, 0);
      chk("R1", "stalled", int'(rx_bytes), 4);
      cyc(1, 1, 0, 0, 0);
      chk("R1", "second beat", int'(rx_bytes), 8);
      cyc(1, 1, 1, 0, 0);
      chk("R2", "done after gaps", int'(done_bytes), 12);
      chk("R7", "clean after gaps", int'(mon_err), 0);
      cyc(0, 0, 0, 0, 0);
   endtask

   task automatic t_early();
      do_reset();
      cyc(1, 0, 0, 0, 0);
      chk("R3", "early valid flag", int'(mon_err), 1);
      chk("R3", "no bytes counted", int'(rx_bytes), 0);
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0);
      chk("R10", "flag sticky", int'(mon_err), 1);
      do_reset();
      chk("R10", "flag cleared by reset", int'(mon_err), 0);
      cyc(1, 0, 0, 1, 8);
      chk("R3", "valid with arm strobe", int'(mon_err), 1);
      cyc(0, 0, 0, 0, 0);
   endtask

   task automatic t_trail();
      do_reset();
      cyc(0, 0, 0, 1, 4);
      cyc(1, 1, 1, 0, 0);
      chk("R2", "one-beat packet", int'(done_bytes), 4);
      cyc(1, 0, 0, 0, 0);
      chk("R4", "trailing valid flag only", int'(mon_err), 8);
      cyc(0, 0, 0, 0, 0);
      chk("R4", "still trailing only", int'(mon_err), 8);
   endtask

   task automatic t_short();
      do_reset();
      cyc(0, 0, 0, 1, 16);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 1, 0, 0);
      chk("R5", "short flag", int'(mon_err), 2);
      chk("R5", "short packet completes", int'(pkt_done), 1);
      chk("R5", "short byte total", int'(done_bytes), 8);
      cyc(0, 0, 0, 0, 0);
   endtask

   task automatic t_nolast();
      do_reset();
      cyc(0, 0, 0, 1, 8);
      cyc(1, 1, 0, 0, 0);
      chk("R6", "clean below length", int'(mon_err), 0);
      cyc(1, 1, 0, 0, 0);
      chk("R6", "missing last flag", int'(mon_err), 4);
      cyc(1, 1, 1, 0, 0);
      chk("R6", "late end total", int'(done_bytes), 12);
      chk("R6", "only missing last", int'(mon_err), 4);
      cyc(0, 0, 0, 0, 0);
   endtask

   task automatic t_rearm();
      do_reset();
      cyc(0, 0, 0, 1, 8);
      cyc(0, 0, 0, 1, 16);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 1, 0, 0);
      chk("R8", "second arm ignored", int'(mon_err), 0);
      chk("R8", "first length used", int'(done_bytes), 8);
      cyc(0, 0, 0, 1, 4);
      cyc(1, 1, 1, 0, 0);
      chk("R8", "arm in tail accepted", int'(done_bytes), 4);
      chk("R8", "tail arm clean", int'(mon_err), 0);
      cyc(0, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
      chk("R8", "unarmed after packet", int'(mon_err), 1);
      chk("R8", "no count without arm", int'(rx_bytes), 0);
      cyc(0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_exact();
      t_backpressure();
      t_early();
      t_trail();
      t_short();
      t_nolast();
      t_rearm();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule